// File: doc/BRIEF.md
# SMBus Alert and Host Notify Interrupt Controller

This block sits behind a byte-level SMBus receiver and turns two event sources into interrupt and wake requests. One source is the bus alert status, a level from the receiver. The other is a completed Host Notify message. The receiver reports that message with a one-cycle strobe and presents the notifying device's address byte alongside it.

Software reaches three byte-wide registers over a simple synchronous bus. The control register holds three enables. The status register holds a sticky notify flag that software clears by writing one to it. The read-only address register holds the 7-bit address captured from the most recent notify that was accepted. The combined interrupt goes to one of two outputs, chosen by a configuration input: a system-management interrupt or an ordinary level interrupt line. A separate wake output collects every SMBus wake source. The disable bit that silences the alert interrupt has no effect on wake.

All registers sit on the resume-domain reset only. That reset asserts asynchronously and is released synchronously inside the block.

Top module: `smb_notify_irq`

## Requirements
- R1: While reset is asserted and after it is released, the control register, notify status and captured address all read 00h. With the event inputs low, every output is 0.
- R2: The control register is at offset 0. Bit 2 is alert-disable, bit 1 is notify-wake-enable and bit 0 is notify-interrupt-enable; all three are read/write. Writes to bits 7:3 are ignored, and those bits read 0.
- R3: The alert part of the interrupt request equals alert status AND NOT alert-disable, evaluated combinationally from the current register contents.
- R4: Alert-disable has no effect on wake: wake_o is 1 whenever alert status is 1.
- R5: The notify status is bit 0 at offset 1. It reads 1 starting the cycle after a notify strobe. A write with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. A strobe in the same cycle as a clearing write wins, so the status stays 1.
- R6: The notify part of the interrupt request is notify status AND notify-interrupt-enable. When status is already 1, the request asserts in the cycle right after the enable is written to 1.
- R7: The notify-interrupt-enable value has no effect on whether a strobe sets the notify status.
- R8: wake_o = other_wake_i OR alert status OR (notify status AND notify-wake-enable).
- R9: When smi_sel_i is 1, the combined request appears on smi_o and pirq_o is 0. When smi_sel_i is 0, it appears on pirq_o and smi_o is 0.
- R10: The address register is at offset 2. Bits 7:1 hold the captured 7-bit device address, taken from bits 7:1 of the notify address byte. Bit 0 reads 0. Writes to this register are ignored.
- R11: A strobe captures the address only when notify status is 0. While status is 1, the captured address is held, and a later notify does not overwrite it.
- R12: Reads at offset 3 return 00h, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Resume-domain reset, active low, asynchronous assert |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, combinational |
| alert_sts_i | input | 1 | Alert status level from the SMBus receiver |
| notify_stb_i | input | 1 | One-cycle pulse marking a completed Host Notify |
| notify_addr_i | input | 8 | Address byte of the notify; bits 7:1 are the device address |
| other_wake_i | input | 1 | Other SMBus wake sources, ORed into the wake output |
| smi_sel_i | input | 1 | 1 steers the interrupt to smi_o, 0 steers it to pirq_o |
| pirq_o | output | 1 | Ordinary interrupt request line |
| smi_o | output | 1 | System-management interrupt request |
| wake_o | output | 1 | Combined SMBus wake event |

## Verification
The hardest situation to reach from the ports is the same-cycle collision of a clearing write to the status register and a new notify strobe. It must leave the status set and the earlier address in place. The bench reaches it by first setting status with one address, then driving the clearing write and a strobe with a different address in the same cycle. It reads back both registers afterwards. The level-sensitive enable is reached the same way, by setting status while the enable is 0 and then writing the enable. Beyond those cases, the bench sweeps all eight control values against both status values and all eight combinations of alert, steering and other-wake inputs.

// File: rtl/smbn_pkg.sv
package smbn_pkg;
  localparam int DATA_W     = 8;
  localparam int DEV_ADDR_W = 7;
  localparam int CTRL_W     = 3;

  typedef struct packed {
    logic alert_dis;
    logic ntf_wake_en;
    logic ntf_irq_en;
  } ctrl_t;
endpackage

// File: rtl/smbn_regs.sv
module smbn_regs
  import smbn_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int OFF_CTRL  = 0,
  parameter int OFF_STAT  = 1,
  parameter int OFF_NADDR = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  ntf_sts,
  input  logic [DEV_ADDR_W-1:0] ntf_dev,
  output ctrl_t                 ctrl,
  output logic                  sts_clr,
  output logic [DATA_W-1:0]     bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_NADDR = ADDR_W'(OFF_NADDR);

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;
  logic  unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_W];

  always_comb begin
    ctrl_we = bus_wr && (bus_addr == A_CTRL);
    ctrl_d  = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  assign sts_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, ntf_sts};
      A_NADDR: bus_rdata = {ntf_dev, 1'b0};
      default: bus_rdata = '0;
    endcase
  end

  // R2: a control write lands in the register on the following cycle
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

  // R12: a write to any other offset leaves the control register alone
  p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/smbn_notify.sv
module smbn_notify
  import smbn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stb,
  input  logic [DATA_W-1:0]     addr_byte,
  input  logic                  clr,
  output logic                  sts,
  output logic [DEV_ADDR_W-1:0] dev
);
  logic                  sts_q, sts_d;
  logic [DEV_ADDR_W-1:0] dev_q;
  logic                  cap_en;
  logic                  unused_rsvd;

  assign unused_rsvd = addr_byte[0];

  always_comb begin
    sts_d  = stb | (sts_q & ~clr);
    cap_en = stb & ~sts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dev_q <= '0;
    else if (cap_en) dev_q <= addr_byte[DATA_W-1:1];
  end

  assign sts = sts_q;
  assign dev = dev_q;

  // R5: a strobe always leaves status set, even against a clear
  p_sts_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> sts_q);

  // R11: address is frozen while status is held
  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q |=> $stable(dev_q));

  // R5: without a strobe, a clear drops status
  p_sts_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !stb) |=> !sts_q);
endmodule

// File: rtl/smbn_irq_route.sv
module smbn_irq_route
  import smbn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alert_sts,
  input  logic  ntf_sts,
  input  ctrl_t ctrl,
  input  logic  other_wake,
  input  logic  smi_sel,
  output logic  pirq,
  output logic  smi,
  output logic  wake
);
  logic alert_req, ntf_req, ntf_wake, irq;

  always_comb begin
    alert_req = alert_sts & ~ctrl.alert_dis;
    ntf_req   = ntf_sts & ctrl.ntf_irq_en;
    ntf_wake  = ntf_sts & ctrl.ntf_wake_en;
    irq       = alert_req | ntf_req;
    pirq      = irq & ~smi_sel;
    smi       = irq & smi_sel;
    wake      = other_wake | alert_sts | ntf_wake;
  end

  // R9: the two interrupt outputs never fire together
  p_one_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pirq && smi));

  // R4: alert always reaches wake
  p_alert_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alert_sts |-> wake);

  // R6: enabled notify status always produces a request somewhere
  p_ntf_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_sts && ctrl.ntf_irq_en) |-> (pirq || smi));

  // R3: a disabled alert with no notify request gives no interrupt
  p_alert_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.alert_dis && !(ntf_sts && ctrl.ntf_irq_en)) |-> !(pirq || smi));
endmodule

// File: rtl/smb_notify_irq.sv
module smb_notify_irq
  import smbn_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int OFF_CTRL  = 0,
  parameter int OFF_STAT  = 1,
  parameter int OFF_NADDR = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              alert_sts_i,
  input  logic              notify_stb_i,
  input  logic [7:0]        notify_addr_i,
  input  logic              other_wake_i,
  input  logic              smi_sel_i,
  output logic              pirq_o,
  output logic              smi_o,
  output logic              wake_o
);
  logic [SYNC_LEN-1:0]   rst_sync_q;
  logic                  rst_n_s;
  ctrl_t                 ctrl;
  logic                  sts_clr, ntf_sts;
  logic [DEV_ADDR_W-1:0] ntf_dev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_LEN-1];

  smbn_regs #(
    .ADDR_W(ADDR_W), .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT), .OFF_NADDR(OFF_NADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ntf_sts(ntf_sts), .ntf_dev(ntf_dev),
    .ctrl(ctrl), .sts_clr(sts_clr), .bus_rdata(bus_rdata)
  );

  smbn_notify u_notify (
    .clk(clk), .rst_n(rst_n_s), .stb(notify_stb_i), .addr_byte(notify_addr_i),
    .clr(sts_clr), .sts(ntf_sts), .dev(ntf_dev)
  );

  smbn_irq_route u_route (
    .clk(clk), .rst_n(rst_n_s), .alert_sts(alert_sts_i), .ntf_sts(ntf_sts),
    .ctrl(ctrl), .other_wake(other_wake_i), .smi_sel(smi_sel_i),
    .pirq(pirq_o), .smi(smi_o), .wake(wake_o)
  );
endmodule

// File: tb/sim_smb_notify_irq.sv
module sim_smb_notify_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata, bus_rdata, notify_addr_i;
  logic       alert_sts_i, notify_stb_i, other_wake_i, smi_sel_i;
  logic       pirq_o, smi_o, wake_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  smb_notify_irq u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alert_sts_i(alert_sts_i),
    .notify_stb_i(notify_stb_i), .notify_addr_i(notify_addr_i),
    .other_wake_i(other_wake_i), .smi_sel_i(smi_sel_i),
    .pirq_o(pirq_o), .smi_o(smi_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic notify(input logic [7:0] ab);
    @(negedge clk);
    notify_stb_i = 1'b1; notify_addr_i = ab;
    @(negedge clk);
    notify_stb_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    alert_sts_i = 1'b0; notify_stb_i = 1'b0; notify_addr_i = '0;
    other_wake_i = 1'b0; smi_sel_i = 1'b0;
    #20;
    // R1: state during reset
    rd("R1 ctrl in reset", 2'd0, 8'h00);
    rd("R1 sts in reset", 2'd1, 8'h00);
    rd("R1 naddr in reset", 2'd2, 8'h00);
    chk("R1 outputs in reset", {5'b0, pirq_o, smi_o, wake_o}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd("R1 ctrl after reset", 2'd0, 8'h00);
    rd("R1 sts after reset", 2'd1, 8'h00);
    rd("R1 naddr after reset", 2'd2, 8'h00);

    // R2: reserved bits drop, defined bits hold
    wr(2'd0, 8'hFF); rd("R2 ctrl ff", 2'd0, 8'h07);
    wr(2'd0, 8'hFA); rd("R2 ctrl fa", 2'd0, 8'h02);
    wr(2'd0, 8'h00); rd("R2 ctrl 00", 2'd0, 8'h00);

    // R7: status set regardless of enable; R10 captured address layout
    notify(8'hA5);
    rd("R7 sts set with ie=0", 2'd1, 8'h01);
    rd("R10 naddr capture", 2'd2, 8'hA4);
    wr(2'd2, 8'h3C); rd("R10 naddr write ignored", 2'd2, 8'hA4);
    // R12: unmapped offset
    wr(2'd3, 8'hFF);
    rd("R12 offset3 reads 0", 2'd3, 8'h00);
    rd("R12 ctrl unchanged", 2'd0, 8'h00);
    rd("R12 sts unchanged", 2'd1, 8'h01);
    // R6: enable written while status already set
    chk("R6 no irq before enable", {7'b0, pirq_o}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R6 irq right after enable", {7'b0, pirq_o}, 8'h01);
    // R11: second notify does not overwrite
    notify(8'h42);
    rd("R11 addr held", 2'd2, 8'hA4);
    // R5: write 0 leaves status
    wr(2'd1, 8'hFE); rd("R5 write0 keeps sts", 2'd1, 8'h01);
    // R5: collision, strobe wins; R11 address still held
    @(negedge clk);
    bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'h01;
    notify_stb_i = 1'b1; notify_addr_i = 8'h66;
    @(negedge clk);
    bus_wr = 1'b0; notify_stb_i = 1'b0;
    rd("R5 strobe beats clear", 2'd1, 8'h01);
    rd("R11 addr held on collision", 2'd2, 8'hA4);
    wr(2'd1, 8'h01); rd("R5 clear", 2'd1, 8'h00);
    notify(8'h66); rd("R11 recapture after clear", 2'd2, 8'h66);
    wr(2'd1, 8'h01);
    notify(8'h81); rd("R7 sts set with ie=1", 2'd1, 8'h01);

    // R3 R4 R6 R8 R9: exhaustive sweep of ctrl x status x inputs
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        wr(2'd1, 8'h01);
        if (s == 1) notify(8'h10);
        wr(2'd0, 8'(c));
        for (int v = 0; v < 8; v++) begin
          logic a, sel, ow, irq, wk;
          @(negedge clk);
          a = v[0]; sel = v[1]; ow = v[2];
          alert_sts_i = a; smi_sel_i = sel; other_wake_i = ow;
          #1;
          irq = (a & ~c[2]) | (s[0] & c[0]);
          wk  = ow | a | (s[0] & c[1]);
          chk("R3/R6/R9 pirq", {7'b0, pirq_o}, {7'b0, irq & ~sel});
          chk("R3/R6/R9 smi", {7'b0, smi_o}, {7'b0, irq & sel});
          chk("R4/R8 wake", {7'b0, wake_o}, {7'b0, wk});
        end
        alert_sts_i = 1'b0; smi_sel_i = 1'b0; other_wake_i = 1'b0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule